// File: doc/BRIEF.md
# AXI4-Lite Address Window Splitter

This block sits between one upstream AXI4-Lite manager and several downstream AXI4-Lite subordinates. Each downstream port owns one address window, defined by a base, a span and a stride. A write or read that lands in a window is steered only to that window's port. The address it carries there is the offset from the window base, folded over the stride. This folding lets an arrayed group of identical subordinates share one port, each seeing the same local address map. Write data and strobes pass through unchanged. Responses are muxed back from whichever port was addressed.

The write and read paths decode on their own, and each allows one transaction in flight. Each path records the decoded port until its response handshake completes. An address that falls in no window is completed by the block itself with a decode-error response, and nothing is forwarded downstream. Within a write, the address and the data may arrive in any order. The data is held off upstream until the write address has been decoded.

Top module: `axil_addr_splitter`

## Requirements
- R1: During a write, AWVALID and WVALID are raised only on the downstream port whose window holds the write address (base <= addr < base + span, lowest port index on overlap). On an unmapped write, neither valid is raised on any port.
- R2: The downstream AWADDR of the selected port is (write address - window base) modulo the window stride. The stride is a power of two.
- R3: WDATA and WSTRB reach the selected downstream port bit for bit.
- R4: ARVALID is raised only on the port decoded from the read address, and none is raised for an unmapped read. ARADDR is rebased as in R2.
- R5: BRESP is taken from the port that was written. RDATA and RRESP are taken from the port that was read. Upstream BVALID and RVALID hold until accepted.
- R6: Upstream AWREADY, WREADY and ARREADY follow the ready of the selected downstream port. For an unmapped address they are high.
- R7: An unmapped write is accepted and answered with BRESP = 2'b11. An unmapped read is answered with RRESP = 2'b11 and RDATA = 0.
- R8: Upstream WREADY stays low while no write address is presented or held. Data offered first is therefore held upstream until the address arrives.
- R9: After an address is accepted on a path, that path's upstream address ready stays low until its response handshake completes.
- R10: After reset, no upstream response valid and no downstream channel valid is raised, and WREADY is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Clock |
| aresetn | input | 1 | Synchronous reset, active low |
| s_awvalid | input | 1 | Upstream write address valid |
| s_awready | output | 1 | Upstream write address ready |
| s_awaddr | input | AW | Upstream write address |
| s_wvalid | input | 1 | Upstream write data valid |
| s_wready | output | 1 | Upstream write data ready |
| s_wdata | input | DW | Upstream write data |
| s_wstrb | input | DW/8 | Upstream byte strobes |
| s_bvalid | output | 1 | Upstream write response valid |
| s_bready | input | 1 | Upstream write response ready |
| s_bresp | output | 2 | Upstream write response code |
| s_arvalid | input | 1 | Upstream read address valid |
| s_arready | output | 1 | Upstream read address ready |
| s_araddr | input | AW | Upstream read address |
| s_rvalid | output | 1 | Upstream read data valid |
| s_rready | input | 1 | Upstream read data ready |
| s_rdata | output | DW | Upstream read data |
| s_rresp | output | 2 | Upstream read response code |
| m_awvalid | output | N | Per-port write address valid |
| m_awready | input | N | Per-port write address ready |
| m_awaddr | output | N*AW | Per-port rebased write address |
| m_wvalid | output | N | Per-port write data valid |
| m_wready | input | N | Per-port write data ready |
| m_wdata | output | N*DW | Per-port write data |
| m_wstrb | output | N*DW/8 | Per-port byte strobes |
| m_bvalid | input | N | Per-port write response valid |
| m_bready | output | N | Per-port write response ready |
| m_bresp | input | N*2 | Per-port write response code |
| m_arvalid | output | N | Per-port read address valid |
| m_arready | input | N | Per-port read address ready |
| m_araddr | output | N*AW | Per-port rebased read address |
| m_rvalid | input | N | Per-port read data valid |
| m_rready | output | N | Per-port read data ready |
| m_rdata | input | N*DW | Per-port read data |
| m_rresp | input | N*2 | Per-port read response code |

## Verification
A wrong stored port index shows up within the same transaction, with no delay. The write data goes to a second port after the address went to the first, so two ports record activity. Otherwise the response code or read data carries another port's signature, or the upstream response never arrives and the bench stalls. A stuck done flag or state shows on the next transaction: either the address ready stays low for good, or a second address is accepted while a response is still owed. A wrong rebase mask shows at once in the local address the addressed port captures.

// File: rtl/axil_split_pkg.sv
`timescale 1ns/1ps
// Shared response codes and path state types for the address splitter.
package axil_split_pkg;

    localparam logic [1:0] RESP_OKAY   = 2'b00;
    localparam logic [1:0] RESP_DECERR = 2'b11;

    typedef enum logic {
        WS_COLLECT = 1'b0,
        WS_RESP    = 1'b1
    } wr_state_e;

    typedef enum logic {
        RS_IDLE = 1'b0,
        RS_RESP = 1'b1
    } rd_state_e;

endpackage

// File: rtl/axil_win_decode.sv
`timescale 1ns/1ps
// Window decoder: compares one address against every window and produces
// the hit flag, the winning port index (lowest index wins on overlap) and
// the rebased local address for every port.
// Assumes each stride is a power of two, so the fold is a mask.
module axil_win_decode #(
    parameter int              N        = 3,
    parameter int              AW       = 16,
    parameter int              IW       = 2,
    parameter logic [N*AW-1:0] WIN_BASE = '0,
    parameter logic [N*AW-1:0] WIN_SPAN = '0,
    parameter logic [N*AW-1:0] WIN_STRD = '0
) (
    input  logic [AW-1:0]   addr,
    output logic            hit,
    output logic [IW-1:0]   idx,
    output logic [N*AW-1:0] local_addr
);

    logic [N-1:0] win_hit;

    for (genvar i = 0; i < N; i++) begin : g_win
        localparam logic [AW-1:0] BASE = WIN_BASE[i*AW +: AW];
        localparam logic [AW-1:0] SPAN = WIN_SPAN[i*AW +: AW];
        localparam logic [AW-1:0] MASK = WIN_STRD[i*AW +: AW] - {{(AW-1){1'b0}}, 1'b1};
        // Range compare done one bit wider so a window ending at the top does not wrap.
        assign win_hit[i] = ({1'b0, addr} >= {1'b0, BASE}) &&
                            ({1'b0, addr} <  ({1'b0, BASE} + {1'b0, SPAN}));
        // Offset from the base, folded over the stride.
        assign local_addr[i*AW +: AW] = (addr - BASE) & MASK;
    end

    // Priority pick: scan from the top so the lowest hitting index is kept.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (win_hit[i]) idx = IW'(i);
        end
    end

    assign hit = |win_hit;

endmodule

// File: rtl/axil_split_wr.sv
`timescale 1ns/1ps
// Write path: steers AW and W to the decoded port, holds W upstream until an
// address is known, remembers the owning port and returns its B response.
// Unmapped writes are absorbed and answered with a decode error.
// Assumes one write in flight and a stable address while AWVALID is high.
module axil_split_wr
    import axil_split_pkg::*;
#(
    parameter int N  = 3,
    parameter int IW = 2
) (
    input  logic          aclk,
    input  logic          aresetn,
    input  logic          s_awvalid,
    output logic          s_awready,
    input  logic          s_wvalid,
    output logic          s_wready,
    output logic          s_bvalid,
    input  logic          s_bready,
    output logic [1:0]    s_bresp,
    input  logic          dec_hit,
    input  logic [IW-1:0] dec_idx,
    output logic [N-1:0]  m_awvalid,
    input  logic [N-1:0]  m_awready,
    output logic [N-1:0]  m_wvalid,
    input  logic [N-1:0]  m_wready,
    input  logic [N-1:0]  m_bvalid,
    output logic [N-1:0]  m_bready,
    input  logic [N*2-1:0] m_bresp
);

    wr_state_e     state_q;
    logic          aw_done_q;
    logic          w_done_q;
    logic          miss_q;
    logic [IW-1:0] idx_q;

    logic          route_ok;
    logic          route_miss;
    logic [IW-1:0] route_idx;
    logic          aw_hs;
    logic          w_hs;
    logic          b_hs;
    logic [1:0]    bresp_arr [N];

    for (genvar i = 0; i < N; i++) begin : g_bresp
        assign bresp_arr[i] = m_bresp[i*2 +: 2];
    end

    // Route source: live decode until the address is taken, stored copy after.
    assign route_ok   = aw_done_q | s_awvalid;
    assign route_idx  = aw_done_q ? idx_q  : dec_idx;
    assign route_miss = aw_done_q ? miss_q : !dec_hit;

    assign aw_hs = s_awvalid & s_awready;
    assign w_hs  = s_wvalid  & s_wready;
    assign b_hs  = s_bvalid  & s_bready;

    // Channel steering and upstream ready/response selection.
    always_comb begin
        m_awvalid = '0;
        m_wvalid  = '0;
        m_bready  = '0;
        s_awready = 1'b0;
        s_wready  = 1'b0;
        s_bvalid  = 1'b0;
        s_bresp   = RESP_OKAY;
        if (state_q == WS_COLLECT) begin
            if (!aw_done_q) begin
                s_awready = route_miss ? 1'b1 : m_awready[route_idx];
                if (s_awvalid && !route_miss) m_awvalid[route_idx] = 1'b1;
            end
            if (!w_done_q && route_ok) begin
                s_wready = route_miss ? 1'b1 : m_wready[route_idx];
                if (s_wvalid && !route_miss) m_wvalid[route_idx] = 1'b1;
            end
        end else if (miss_q) begin
            s_bvalid = 1'b1;
            s_bresp  = RESP_DECERR;
        end else begin
            s_bvalid        = m_bvalid[idx_q];
            s_bresp         = bresp_arr[idx_q];
            m_bready[idx_q] = s_bready;
        end
    end

    // Transaction bookkeeping: capture route, track both halves, release on B.
    always_ff @(posedge aclk) begin
        if (!aresetn) begin
            state_q   <= WS_COLLECT;
            aw_done_q <= 1'b0;
            w_done_q  <= 1'b0;
            miss_q    <= 1'b0;
            idx_q     <= '0;
        end else if (state_q == WS_COLLECT) begin
            if (aw_hs) begin
                aw_done_q <= 1'b1;
                idx_q     <= dec_idx;
                miss_q    <= !dec_hit;
            end
            if (w_hs) w_done_q <= 1'b1;
            if ((aw_done_q || aw_hs) && (w_done_q || w_hs)) state_q <= WS_RESP;
        end else if (b_hs) begin
            state_q   <= WS_COLLECT;
            aw_done_q <= 1'b0;
            w_done_q  <= 1'b0;
        end
    end

    p_aw_onehot_r1: assert property (@(posedge aclk) disable iff (!aresetn)
        $onehot0(m_awvalid));
    p_w_onehot_r1: assert property (@(posedge aclk) disable iff (!aresetn)
        $onehot0(m_wvalid));
    p_one_wr_r9: assert property (@(posedge aclk) disable iff (!aresetn)
        (s_awvalid && s_awready) |=> !s_awready);
    p_b_hold_r5: assert property (@(posedge aclk) disable iff (!aresetn)
        (s_bvalid && !s_bready) |=> s_bvalid);

endmodule

// File: rtl/axil_split_rd.sv
`timescale 1ns/1ps
// Read path: steers AR to the decoded port, remembers the owner and muxes
// its R channel back. Unmapped reads return zero data with a decode error.
// Assumes one read in flight.
module axil_split_rd
    import axil_split_pkg::*;
#(
    parameter int N  = 3,
    parameter int DW = 32,
    parameter int IW = 2
) (
    input  logic           aclk,
    input  logic           aresetn,
    input  logic           s_arvalid,
    output logic           s_arready,
    output logic           s_rvalid,
    input  logic           s_rready,
    output logic [DW-1:0]  s_rdata,
    output logic [1:0]     s_rresp,
    input  logic           dec_hit,
    input  logic [IW-1:0]  dec_idx,
    output logic [N-1:0]   m_arvalid,
    input  logic [N-1:0]   m_arready,
    input  logic [N-1:0]   m_rvalid,
    output logic [N-1:0]   m_rready,
    input  logic [N*DW-1:0] m_rdata,
    input  logic [N*2-1:0] m_rresp
);

    rd_state_e     state_q;
    logic          miss_q;
    logic [IW-1:0] idx_q;
    logic          ar_hs;
    logic          r_hs;
    logic [DW-1:0] rdata_arr [N];
    logic [1:0]    rresp_arr [N];

    for (genvar i = 0; i < N; i++) begin : g_rsrc
        assign rdata_arr[i] = m_rdata[i*DW +: DW];
        assign rresp_arr[i] = m_rresp[i*2 +: 2];
    end

    assign ar_hs = s_arvalid & s_arready;
    assign r_hs  = s_rvalid  & s_rready;

    // Address steering while idle, response mux while a read is owed.
    always_comb begin
        m_arvalid = '0;
        m_rready  = '0;
        s_arready = 1'b0;
        s_rvalid  = 1'b0;
        s_rdata   = '0;
        s_rresp   = RESP_OKAY;
        if (state_q == RS_IDLE) begin
            s_arready = dec_hit ? m_arready[dec_idx] : 1'b1;
            if (s_arvalid && dec_hit) m_arvalid[dec_idx] = 1'b1;
        end else if (miss_q) begin
            s_rvalid = 1'b1;
            s_rresp  = RESP_DECERR;
        end else begin
            s_rvalid        = m_rvalid[idx_q];
            s_rdata         = rdata_arr[idx_q];
            s_rresp         = rresp_arr[idx_q];
            m_rready[idx_q] = s_rready;
        end
    end

    // Owner capture on AR, release on R.
    always_ff @(posedge aclk) begin
        if (!aresetn) begin
            state_q <= RS_IDLE;
            miss_q  <= 1'b0;
            idx_q   <= '0;
        end else if (state_q == RS_IDLE) begin
            if (ar_hs) begin
                state_q <= RS_RESP;
                idx_q   <= dec_idx;
                miss_q  <= !dec_hit;
            end
        end else if (r_hs) begin
            state_q <= RS_IDLE;
        end
    end

    p_ar_onehot_r4: assert property (@(posedge aclk) disable iff (!aresetn)
        $onehot0(m_arvalid));
    p_one_rd_r9: assert property (@(posedge aclk) disable iff (!aresetn)
        (s_arvalid && s_arready) |=> !s_arready);
    p_r_hold_r5: assert property (@(posedge aclk) disable iff (!aresetn)
        (s_rvalid && !s_rready) |=> s_rvalid);

endmodule

// File: rtl/axil_addr_splitter.sv
`timescale 1ns/1ps
// One-to-N AXI4-Lite splitter. Each downstream port owns the window
// [base, base+span) and sees addresses rebased modulo its stride.
// Write and read paths decode independently, one transaction in flight each.
// Assumes power-of-two strides; overlapping windows resolve to the lowest index.
module axil_addr_splitter #(
    parameter int              N        = 3,
    parameter int              AW       = 16,
    parameter int              DW       = 32,
    parameter logic [N*AW-1:0] WIN_BASE = {16'h8000, 16'h2000, 16'h1000},
    parameter logic [N*AW-1:0] WIN_SPAN = {16'h1000, 16'h0400, 16'h0100},
    parameter logic [N*AW-1:0] WIN_STRD = {16'h1000, 16'h0100, 16'h0100}
) (
    input  logic              aclk,
    input  logic              aresetn,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [AW-1:0]     s_awaddr,
    input  logic              s_wvalid,
    output logic              s_wready,
    input  logic [DW-1:0]     s_wdata,
    input  logic [DW/8-1:0]   s_wstrb,
    output logic              s_bvalid,
    input  logic              s_bready,
    output logic [1:0]        s_bresp,
    input  logic              s_arvalid,
    output logic              s_arready,
    input  logic [AW-1:0]     s_araddr,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic [DW-1:0]     s_rdata,
    output logic [1:0]        s_rresp,
    output logic [N-1:0]      m_awvalid,
    input  logic [N-1:0]      m_awready,
    output logic [N*AW-1:0]   m_awaddr,
    output logic [N-1:0]      m_wvalid,
    input  logic [N-1:0]      m_wready,
    output logic [N*DW-1:0]   m_wdata,
    output logic [N*DW/8-1:0] m_wstrb,
    input  logic [N-1:0]      m_bvalid,
    output logic [N-1:0]      m_bready,
    input  logic [N*2-1:0]    m_bresp,
    output logic [N-1:0]      m_arvalid,
    input  logic [N-1:0]      m_arready,
    output logic [N*AW-1:0]   m_araddr,
    input  logic [N-1:0]      m_rvalid,
    output logic [N-1:0]      m_rready,
    input  logic [N*DW-1:0]   m_rdata,
    input  logic [N*2-1:0]    m_rresp
);

    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic          aw_hit;
    logic [IW-1:0] aw_idx;
    logic          ar_hit;
    logic [IW-1:0] ar_idx;

    axil_win_decode #(
        .N(N), .AW(AW), .IW(IW),
        .WIN_BASE(WIN_BASE), .WIN_SPAN(WIN_SPAN), .WIN_STRD(WIN_STRD)
    ) u_aw_dec (
        .addr       (s_awaddr),
        .hit        (aw_hit),
        .idx        (aw_idx),
        .local_addr (m_awaddr)
    );

    axil_win_decode #(
        .N(N), .AW(AW), .IW(IW),
        .WIN_BASE(WIN_BASE), .WIN_SPAN(WIN_SPAN), .WIN_STRD(WIN_STRD)
    ) u_ar_dec (
        .addr       (s_araddr),
        .hit        (ar_hit),
        .idx        (ar_idx),
        .local_addr (m_araddr)
    );

    // Data and strobes fan out to every port; only the selected valid is raised.
    assign m_wdata = {N{s_wdata}};
    assign m_wstrb = {N{s_wstrb}};

    axil_split_wr #(.N(N), .IW(IW)) u_wr (
        .aclk      (aclk),
        .aresetn   (aresetn),
        .s_awvalid (s_awvalid),
        .s_awready (s_awready),
        .s_wvalid  (s_wvalid),
        .s_wready  (s_wready),
        .s_bvalid  (s_bvalid),
        .s_bready  (s_bready),
        .s_bresp   (s_bresp),
        .dec_hit   (aw_hit),
        .dec_idx   (aw_idx),
        .m_awvalid (m_awvalid),
        .m_awready (m_awready),
        .m_wvalid  (m_wvalid),
        .m_wready  (m_wready),
        .m_bvalid  (m_bvalid),
        .m_bready  (m_bready),
        .m_bresp   (m_bresp)
    );

    axil_split_rd #(.N(N), .DW(DW), .IW(IW)) u_rd (
        .aclk      (aclk),
        .aresetn   (aresetn),
        .s_arvalid (s_arvalid),
        .s_arready (s_arready),
        .s_rvalid  (s_rvalid),
        .s_rready  (s_rready),
        .s_rdata   (s_rdata),
        .s_rresp   (s_rresp),
        .dec_hit   (ar_hit),
        .dec_idx   (ar_idx),
        .m_arvalid (m_arvalid),
        .m_arready (m_arready),
        .m_rvalid  (m_rvalid),
        .m_rready  (m_rready),
        .m_rdata   (m_rdata),
        .m_rresp   (m_rresp)
    );

endmodule

// File: tb/axil_addr_splitter_tb.sv
`timescale 1ns/1ps
// Sweeps the address space with writes and reads in three AW/W orderings
// and two ready patterns, against bench-modelled downstream subordinates.
module axil_addr_splitter_tb;

    localparam int N  = 3;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int SW = DW / 8;
    localparam int BASE_I [N] = '{'h1000, 'h2000, 'h8000};
    localparam int SPAN_I [N] = '{'h0100, 'h0400, 'h1000};
    localparam int STRD_I [N] = '{'h0100, 'h0100, 'h1000};

    logic clk = 1'b0;
    logic aresetn = 1'b0;
    always #2.5 clk = ~clk;

    logic              s_awvalid = 1'b0, s_awready;
    logic [AW-1:0]     s_awaddr = '0;
    logic              s_wvalid = 1'b0, s_wready;
    logic [DW-1:0]     s_wdata = '0;
    logic [SW-1:0]     s_wstrb = '0;
    logic              s_bvalid, s_bready = 1'b0;
    logic [1:0]        s_bresp;
    logic              s_arvalid = 1'b0, s_arready;
    logic [AW-1:0]     s_araddr = '0;
    logic              s_rvalid, s_rready = 1'b0;
    logic [DW-1:0]     s_rdata;
    logic [1:0]        s_rresp;
    logic [N-1:0]      m_awvalid, m_awready, m_wvalid, m_wready;
    logic [N-1:0]      m_bvalid, m_bready, m_arvalid, m_arready, m_rvalid, m_rready;
    logic [N*AW-1:0]   m_awaddr, m_araddr;
    logic [N*DW-1:0]   m_wdata, m_rdata;
    logic [N*SW-1:0]   m_wstrb;
    logic [N*2-1:0]    m_bresp, m_rresp;

    axil_addr_splitter u_dut (
        .aclk(clk), .aresetn(aresetn),
        .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr),
        .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wstrb(s_wstrb),
        .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
        .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr),
        .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp),
        .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr),
        .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata), .m_wstrb(m_wstrb),
        .m_bvalid(m_bvalid), .m_bready(m_bready), .m_bresp(m_bresp),
        .m_arvalid(m_arvalid), .m_arready(m_arready), .m_araddr(m_araddr),
        .m_rvalid(m_rvalid), .m_rready(m_rready), .m_rdata(m_rdata), .m_rresp(m_rresp)
    );

    // Downstream subordinate models.
    logic          slow = 1'b0;
    logic          mon_clr = 1'b0;
    logic [7:0]    cyc;
    logic          rdy;
    logic [N-1:0]  aw_got, w_got, bv, rv, seen_aw, seen_w, seen_ar;
    logic [AW-1:0] cap_aw [N];
    logic [AW-1:0] cap_ar [N];
    logic [DW-1:0] cap_w  [N];
    logic [SW-1:0] cap_s  [N];

    assign rdy = slow ? cyc[0] : 1'b1;
    assign m_awready = {N{rdy}};
    assign m_wready  = {N{rdy}};
    assign m_arready = {N{rdy}};
    assign m_bvalid  = bv;
    assign m_rvalid  = rv;

    for (genvar i = 0; i < N; i++) begin : g_sub
        assign m_bresp[i*2 +: 2] = (i == 1) ? 2'b10 : 2'b00;
        assign m_rresp[i*2 +: 2] = (i == 2) ? 2'b01 : 2'b00;
        assign m_rdata[i*DW +: DW] = {8'hA0 + 8'(i), 8'h00, cap_ar[i]};
    end

    always_ff @(posedge clk) begin
        if (!aresetn) begin
            cyc <= '0; aw_got <= '0; w_got <= '0; bv <= '0; rv <= '0;
            seen_aw <= '0; seen_w <= '0; seen_ar <= '0;
            for (int i = 0; i < N; i++) begin
                cap_aw[i] <= '0; cap_ar[i] <= '0; cap_w[i] <= '0; cap_s[i] <= '0;
            end
        end else begin
            cyc <= cyc + 8'd1;
            seen_aw <= mon_clr ? '0 : (seen_aw | m_awvalid);
            seen_w  <= mon_clr ? '0 : (seen_w  | m_wvalid);
            seen_ar <= mon_clr ? '0 : (seen_ar | m_arvalid);
            for (int i = 0; i < N; i++) begin
                if (m_awvalid[i] && m_awready[i]) begin
                    cap_aw[i] <= m_awaddr[i*AW +: AW]; aw_got[i] <= 1'b1;
                end
                if (m_wvalid[i] && m_wready[i]) begin
                    cap_w[i] <= m_wdata[i*DW +: DW]; cap_s[i] <= m_wstrb[i*SW +: SW];
                    w_got[i] <= 1'b1;
                end
                if (aw_got[i] && w_got[i] && !bv[i]) bv[i] <= 1'b1;
                if (bv[i] && m_bready[i]) begin
                    bv[i] <= 1'b0; aw_got[i] <= 1'b0; w_got[i] <= 1'b0;
                end
                if (m_arvalid[i] && m_arready[i]) begin
                    cap_ar[i] <= m_araddr[i*AW +: AW]; rv[i] <= 1'b1;
                end
                if (rv[i] && m_rready[i]) rv[i] <= 1'b0;
            end
        end
    end

    int n_tests = 0;
    int n_fail  = 0;

    task automatic check_eq(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic int exp_port(int a);
        for (int i = 0; i < N; i++)
            if (a >= BASE_I[i] && a < BASE_I[i] + SPAN_I[i]) return i;
        return -1;
    endfunction

    function automatic int exp_local(int a, int p);
        return (a - BASE_I[p]) % STRD_I[p];
    endfunction

    function automatic logic [N-1:0] exp_mask(int p);
        logic [N-1:0] m = '0;
        if (p >= 0) m[p] = 1'b1;
        return m;
    endfunction

    task automatic clear_monitor();
        @(negedge clk) mon_clr = 1'b1;
        @(negedge clk) mon_clr = 1'b0;
    endtask

    // order 0: AW and W together; 1: W offered three cycles early; 2: AW first.
    task automatic do_write(int a, logic [DW-1:0] d, logic [SW-1:0] st, int order);
        int  p = exp_port(a);
        bit  aw_left = 1'b1, w_left = 1'b1, aw_hs, w_hs;
        int  k = 0;
        logic [1:0] resp;
        clear_monitor();
        while (aw_left || w_left) begin
            @(negedge clk);
            s_awaddr  = AW'(a);
            s_wdata   = d;
            s_wstrb   = st;
            s_awvalid = aw_left && (order != 1 || k >= 3);
            s_wvalid  = w_left  && (order != 2 || k >= 2);
            #1;
            if (order == 1 && k < 3) check_eq("R8", "wready before address", 32'(s_wready), 32'd0);
            if (order == 0 && k == 0)
                check_eq("R6", "awready follows port", 32'(s_awready), (p >= 0) ? 32'(rdy) : 32'd1);
            aw_hs = s_awvalid && s_awready;
            w_hs  = s_wvalid && s_wready;
            @(posedge clk);
            if (aw_hs) aw_left = 1'b0;
            if (w_hs)  w_left  = 1'b0;
            k++;
        end
        @(negedge clk);
        s_awvalid = 1'b0; s_wvalid = 1'b0; s_bready = 1'b1;
        #1;
        check_eq("R9", "awready while write owed", 32'(s_awready), 32'd0);
        while (!s_bvalid) begin @(negedge clk); #1; end
        resp = s_bresp;
        @(posedge clk);
        @(negedge clk) s_bready = 1'b0;
        check_eq("R1", "ports seeing AWVALID", 32'(seen_aw), 32'(exp_mask(p)));
        check_eq("R1", "ports seeing WVALID", 32'(seen_w), 32'(exp_mask(p)));
        if (p >= 0) begin
            check_eq("R2", "rebased AWADDR", 32'(cap_aw[p]), 32'(exp_local(a, p)));
            check_eq("R3", "WDATA at port", cap_w[p], d);
            check_eq("R3", "WSTRB at port", 32'(cap_s[p]), 32'(st));
            check_eq("R5", "BRESP from port", 32'(resp), (p == 1) ? 32'd2 : 32'd0);
        end else begin
            check_eq("R7", "BRESP unmapped", 32'(resp), 32'd3);
        end
    endtask

    task automatic do_read(int a);
        int  p = exp_port(a);
        bit  hs;
        logic [DW-1:0] d;
        logic [1:0] resp;
        clear_monitor();
        do begin
            @(negedge clk);
            s_araddr = AW'(a); s_arvalid = 1'b1;
            #1;
            hs = s_arready;
            @(posedge clk);
        end while (!hs);
        @(negedge clk);
        s_arvalid = 1'b0; s_rready = 1'b1;
        #1;
        check_eq("R9", "arready while read owed", 32'(s_arready), 32'd0);
        while (!s_rvalid) begin @(negedge clk); #1; end
        d = s_rdata; resp = s_rresp;
        @(posedge clk);
        @(negedge clk) s_rready = 1'b0;
        check_eq("R4", "ports seeing ARVALID", 32'(seen_ar), 32'(exp_mask(p)));
        if (p >= 0) begin
            check_eq("R4", "RDATA carries rebased ARADDR",
                     d, {8'hA0 + 8'(p), 8'h00, 16'(exp_local(a, p))});
            check_eq("R5", "RRESP from port", 32'(resp), (p == 2) ? 32'd1 : 32'd0);
        end else begin
            check_eq("R7", "RDATA unmapped", d, 32'd0);
            check_eq("R7", "RRESP unmapped", 32'(resp), 32'd3);
        end
    endtask

    task automatic run_pair(int a, int cnt);
        slow = ((cnt / 3) % 2) == 1;
        do_write(a, {16'(a), ~16'(a)} ^ 32'(cnt), 4'(cnt), cnt % 3);
        do_read(a);
    endtask

    initial begin
        int cnt = 0;
        repeat (5) @(posedge clk);
        @(negedge clk) aresetn = 1'b1;
        #1;
        check_eq("R10", "bvalid after reset", 32'(s_bvalid), 32'd0);
        check_eq("R10", "rvalid after reset", 32'(s_rvalid), 32'd0);
        check_eq("R10", "wready after reset", 32'(s_wready), 32'd0);
        check_eq("R10", "downstream valids after reset",
                 32'({m_awvalid, m_wvalid, m_arvalid}), 32'd0);
        // Window edges, array stride edges and the top of the space.
        for (int i = 0; i < N; i++) begin
            if (BASE_I[i] >= 4) begin run_pair(BASE_I[i] - 4, cnt); cnt++; end
            run_pair(BASE_I[i], cnt); cnt++;
            run_pair(BASE_I[i] + SPAN_I[i] - 4, cnt); cnt++;
            run_pair(BASE_I[i] + SPAN_I[i], cnt); cnt++;
        end
        run_pair('h20FC, cnt); cnt++;
        run_pair('h2104, cnt); cnt++;
        run_pair('hFFFC, cnt); cnt++;
        // Whole-space sweep with a drifting offset inside each 256-byte page.
        for (int j = 0; j < 256; j++) begin
            run_pair(j * 'h100 + ((j * 'h14) & 'hFC), cnt);
            cnt++;
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule